// File: doc/BRIEF.md
# Endian-Aware Byte-Enable Generator

This block turns one CPU transfer request into the byte-lane strobes for an eight-lane memory and a four-lane PCI data phase. It takes the three low address bits as they appear on the CPU pins, the transfer size, the endian mode and an I/O-cycle flag. A start strobe captures the request. One clock later the block presents three results:

- the active-low column strobes, one for each memory byte lane;
- the active-low PCI byte enables;
- the PCI address bits AD2 and AD[1:0].

All of these stay fixed until the next start.

In little-endian mode the CPU has already scrambled the low address bits according to the transfer size. The block first reverses that scrambling to find the true target byte. The strobes are then derived from the target bytes, so one memory image serves both modes.

The block also raises three error flags:

- a transfer that touches both 4-byte halves, so it cannot be one PCI data phase;
- a transfer that runs past the 8-byte group;
- a misaligned little-endian transfer, which the CPU would reject with a machine check.

For the last two flags no strobes are asserted.

The control is a two-state machine. `ST_IDLE` is the reset state, in which no request has been captured and every strobe is inactive. `ST_HOLD` means a captured result is on the outputs. The transition `ST_IDLE -> ST_HOLD` is taken on start. The transition `ST_HOLD -> ST_HOLD` is also taken on start and reloads the result. With no start, each state holds itself.

Top module: `bemask_gen`

## Requirements
- R1: After reset, `valid` is 0, every bit of `cas_n` and `cbe_n` is 1, `ad2` and `ad_low` are 0, and all three error flags are 0.
- R2: A request sampled with `start` high at a rising clock edge appears on the outputs after that edge, with `valid` at 1. The outputs stay unchanged until the next sampled start.
- R3: Size is coded in `xfer_size` as 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. In little-endian mode (`le_mode`=1), target address = `cpu_addr` XOR 111, 110, 100 or 000 respectively. In big-endian mode the target address equals `cpu_addr`.
- R4: For a legal transfer of n bytes at target address t, `cas_n[i]` is 0 exactly for lanes t to t+n-1. Lane 0 is bit 0.
- R5: When all target bytes lie in one 4-byte half, `ad2` = t[2] and `cbe_n[j]` is 0 exactly for target lanes 4*t[2]+j.
- R6: A legal transfer whose bytes lie in both halves, including every 8-byte transfer, sets `span_err`. It also forces `cbe_n` to 1111 and gives `ad2` = t[2]. `cas_n` still follows R4.
- R7: `ad_low` is 00 unless `io_cycle` is 1, in which case it equals t[1:0].
- R8: In little-endian mode the following transfers set `le_fault`: a 2-byte transfer at an odd `cpu_addr`, a 4-byte transfer with `cpu_addr[1:0]` not 00, and an 8-byte transfer with `cpu_addr` not 000. For such a transfer `cas_n` and `cbe_n` are all 1, `ad2`, `ad_low` and `span_err` are 0, and `wrap_err` is 0.
- R9: A transfer that is not an R8 fault but has t+n > 8 sets `wrap_err`. For it `cas_n` and `cbe_n` are all 1, `ad2`, `ad_low` and `span_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Captures the request on this edge |
| cpu_addr | input | 3 | Low address bits as seen on the CPU pins |
| xfer_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| io_cycle | input | 1 | Request is a PCI I/O cycle |
| le_mode | input | 1 | 1 = little-endian mode |
| valid | output | 1 | A captured result is on the outputs |
| cas_n | output | 8 | Memory column strobes, bit i = lane i, active low |
| cbe_n | output | 4 | PCI byte enables, active low |
| ad2 | output | 1 | PCI address bit 2 (selects the 4-byte half) |
| ad_low | output | 2 | PCI address bits 1:0 |
| span_err | output | 1 | Transfer needs both 4-byte halves |
| le_fault | output | 1 | Misaligned little-endian transfer |
| wrap_err | output | 1 | Transfer runs past the 8-byte group |

## Verification
The bench sweeps every address and size in both modes.

- It targets the little-endian unmunge, since an incorrect XOR pattern would move strobes to the mirror lane.
- It targets the two-byte transfer at target 3, since a design that mishandled the half boundary would drive a partial PCI enable instead of flagging the span.
- It targets every misaligned little-endian case, since a design that skipped the alignment test would assert strobes for requests the CPU rejects.
- It targets the 8-byte-group overrun, since a design that let the lane range wrap around would assert strobes on the wrong lanes.
- It checks that a request presented without start leaves the held result untouched.

// File: rtl/bemask_pkg.sv
package bemask_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } xfer_size_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } bemask_state_t;
endpackage

// File: rtl/bemask_unmunge.sv
module bemask_unmunge #(
    parameter int LANES = 8,
    localparam int AW = $clog2(LANES)
) (
    input  logic [AW-1:0] cpu_addr,
    input  logic [1:0]    size_code,
    input  logic          le_mode,
    output logic [AW-1:0] tgt_addr,
    output logic          misalign
);
    logic [AW-1:0] low_mask;
    logic [AW-1:0] flip;

    always_comb begin
        low_mask = AW'((1 << size_code) - 1);
        flip     = le_mode ? AW'(~low_mask) : '0;
        tgt_addr = cpu_addr ^ flip;
        misalign = le_mode && ((cpu_addr & low_mask) != '0);
    end
endmodule

// File: rtl/bemask_lanes.sv
module bemask_lanes #(
    parameter int LANES = 8,
    localparam int AW   = $clog2(LANES),
    localparam int HALF = LANES / 2
) (
    input  logic [AW-1:0]   tgt_addr,
    input  logic [1:0]      size_code,
    output logic [LANES-1:0] lane_en,
    output logic [HALF-1:0]  pci_en,
    output logic             crosses_half,
    output logic             overrun
);
    logic [AW:0] first_b;
    logic [AW:0] end_b;
    logic [AW:0] last_b;

    always_comb begin
        first_b      = {1'b0, tgt_addr};
        end_b        = first_b + (AW+1)'(1 << size_code);
        last_b       = end_b - 1'b1;
        overrun      = end_b > (AW+1)'(LANES);
        crosses_half = !overrun && (first_b[AW-1] != last_b[AW-1]);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_en[i] = ((AW+1)'(i) >= first_b) && ((AW+1)'(i) < end_b);
    end

    for (genvar j = 0; j < HALF; j++) begin : g_pci
        assign pci_en[j] = tgt_addr[AW-1] ? lane_en[HALF + j] : lane_en[j];
    end
endmodule

// File: rtl/bemask_gen.sv
module bemask_gen
    import bemask_pkg::*;
#(
    parameter int LANES = 8,
    localparam int AW   = $clog2(LANES),
    localparam int HALF = LANES / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   cpu_addr,
    input  logic [1:0]      xfer_size,
    input  logic            io_cycle,
    input  logic            le_mode,
    output logic            valid,
    output logic [LANES-1:0] cas_n,
    output logic [HALF-1:0]  cbe_n,
    output logic            ad2,
    output logic [1:0]      ad_low,
    output logic            span_err,
    output logic            le_fault,
    output logic            wrap_err
);
    bemask_state_t state_q, state_d;

    logic [AW-1:0]    tgt;
    logic             misalign;
    logic [LANES-1:0] lane_en;
    logic [HALF-1:0]  pci_en;
    logic             crosses_half;
    logic             overrun;
    logic             drop;

    bemask_unmunge #(.LANES(LANES)) u_unmunge (
        .cpu_addr (cpu_addr),
        .size_code(xfer_size),
        .le_mode  (le_mode),
        .tgt_addr (tgt),
        .misalign (misalign)
    );

    bemask_lanes #(.LANES(LANES)) u_lanes (
        .tgt_addr    (tgt),
        .size_code   (xfer_size),
        .lane_en     (lane_en),
        .pci_en      (pci_en),
        .crosses_half(crosses_half),
        .overrun     (overrun)
    );

    assign drop = misalign || overrun;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_HOLD;
            ST_HOLD: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cas_n    <= '1;
            cbe_n    <= '1;
            ad2      <= 1'b0;
            ad_low   <= 2'b00;
            span_err <= 1'b0;
            le_fault <= 1'b0;
            wrap_err <= 1'b0;
        end else if (start) begin
            le_fault <= misalign;
            wrap_err <= !misalign && overrun;
            if (drop) begin
                cas_n    <= '1;
                cbe_n    <= '1;
                ad2      <= 1'b0;
                ad_low   <= 2'b00;
                span_err <= 1'b0;
            end else begin
                cas_n    <= ~lane_en;
                cbe_n    <= crosses_half ? '1 : ~pci_en;
                ad2      <= tgt[AW-1];
                ad_low   <= io_cycle ? tgt[1:0] : 2'b00;
                span_err <= crosses_half;
            end
        end
    end

    assign valid = (state_q == ST_HOLD);
endmodule

// File: rtl/bemask_gen_chk.sv
module bemask_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [2:0] cpu_addr,
    input logic [1:0] xfer_size,
    input logic       io_cycle,
    input logic       le_mode,
    input logic       valid,
    input logic [7:0] cas_n,
    input logic [3:0] cbe_n,
    input logic       ad2,
    input logic [1:0] ad_low,
    input logic       span_err,
    input logic       le_fault,
    input logic       wrap_err
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (&cas_n && &cbe_n && !span_err)); // R1

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !start) |=> ($stable(cas_n) && $stable(cbe_n) && $stable(ad2) && $stable(ad_low))); // R2

    AST_START_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid); // R2

    AST_ONE_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && xfer_size == 2'd0) |=> ($countones(~cas_n) == 1)); // R4

    AST_SPAN_NO_PCI: assert property (@(posedge clk) disable iff (!rst_n)
        span_err |-> (&cbe_n && !(&cas_n))); // R6

    AST_MEM_IO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !io_cycle) |=> (ad_low == 2'b00)); // R7

    AST_LE_HALF_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (start && le_mode && xfer_size == 2'd1 && cpu_addr[0]) |=> (le_fault && &cas_n && &cbe_n)); // R8

    AST_BE_DWORD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !le_mode && xfer_size == 2'd3 && cpu_addr != 3'd0) |=> (wrap_err && &cas_n)); // R9

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(le_fault && wrap_err) && !(span_err && (le_fault || wrap_err))); // R8
endmodule

bind bemask_gen bemask_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cpu_addr (cpu_addr),
    .xfer_size(xfer_size),
    .io_cycle (io_cycle),
    .le_mode  (le_mode),
    .valid    (valid),
    .cas_n    (cas_n),
    .cbe_n    (cbe_n),
    .ad2      (ad2),
    .ad_low   (ad_low),
    .span_err (span_err),
    .le_fault (le_fault),
    .wrap_err (wrap_err)
);

// File: tb/bemask_gen_test.sv
module bemask_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] cpu_addr = '0;
    logic [1:0] xfer_size = '0;
    logic       io_cycle = 1'b0;
    logic       le_mode = 1'b0;
    logic       valid;
    logic [7:0] cas_n;
    logic [3:0] cbe_n;
    logic       ad2;
    logic [1:0] ad_low;
    logic       span_err, le_fault, wrap_err;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] e_cas;
    logic [3:0] e_cbe;
    logic       e_ad2, e_span, e_fault, e_wrap;
    logic [1:0] e_low;

    always #10 clk = ~clk;

    bemask_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cpu_addr(cpu_addr),
        .xfer_size(xfer_size), .io_cycle(io_cycle), .le_mode(le_mode),
        .valid(valid), .cas_n(cas_n), .cbe_n(cbe_n), .ad2(ad2), .ad_low(ad_low),
        .span_err(span_err), .le_fault(le_fault), .wrap_err(wrap_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected values built from the requirement text, lane by lane.
    task automatic model(input logic [2:0] a, input logic [1:0] sz, input logic le, input logic io);
        int n, t;
        bit bad_align, lo_hit, hi_hit;
        n = 1 << sz;
        bad_align = 0;
        if (le) begin
            if (sz == 2'd1 && a[0]) bad_align = 1;
            if (sz == 2'd2 && a[1:0] != 2'b00) bad_align = 1;
            if (sz == 2'd3 && a != 3'd0) bad_align = 1;
        end
        case (sz)
            2'd0: t = le ? (a ^ 3'b111) : a;
            2'd1: t = le ? (a ^ 3'b110) : a;
            2'd2: t = le ? (a ^ 3'b100) : a;
            default: t = a;
        endcase
        e_cas = 8'hFF; e_cbe = 4'hF; e_ad2 = 0; e_low = 0;
        e_span = 0; e_fault = bad_align; e_wrap = 0;
        if (bad_align) return;
        if (t + n > 8) begin e_wrap = 1; return; end
        lo_hit = 0; hi_hit = 0;
        for (int k = t; k < t + n; k++) begin
            e_cas[k] = 1'b0;
            if (k < 4) lo_hit = 1; else hi_hit = 1;
        end
        e_ad2 = (t >= 4);
        e_low = io ? 2'(t % 4) : 2'b00;
        if (lo_hit && hi_hit) e_span = 1;
        else for (int k = t; k < t + n; k++) e_cbe[k % 4] = 1'b0;
    endtask

    task automatic xfer(input logic [2:0] a, input logic [1:0] sz, input logic le, input logic io);
        @(negedge clk);
        cpu_addr = a; xfer_size = sz; le_mode = le; io_cycle = io; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " cas_n"}, 32'(cas_n), 32'(e_cas));
        chk({tag, " cbe_n"}, 32'(cbe_n), 32'(e_cbe));
        chk({tag, " ad2"}, 32'(ad2), 32'(e_ad2));
        chk({tag, " ad_low"}, 32'(ad_low), 32'(e_low));
        chk({tag, " flags"}, {29'd0, span_err, le_fault, wrap_err}, {29'd0, e_span, e_fault, e_wrap});
        chk({tag, " valid"}, 32'(valid), 32'd1);
    endtask

    task automatic run_one(input string tag, input logic [2:0] a, input logic [1:0] sz,
                           input logic le, input logic io);
        model(a, sz, le, io);
        xfer(a, sz, le, io);
        check_all(tag);
    endtask

    task automatic t_reset;  // R1
        chk("R1 valid", 32'(valid), 0);
        chk("R1 cas_n", 32'(cas_n), 32'hFF);
        chk("R1 cbe_n", 32'(cbe_n), 32'hF);
        chk("R1 ad", {30'd0, ad2, ad_low[1]} | 32'(ad_low[0]), 0);
        chk("R1 flags", {29'd0, span_err, le_fault, wrap_err}, 0);
    endtask

    task automatic t_stated;  // R4 R5 R6 fixed points
        run_one("R5 half@0", 3'd0, 2'd1, 0, 0);
        chk("R5 half@0 lit cas", 32'(cas_n), 32'hFC);
        chk("R5 half@0 lit cbe", 32'(cbe_n), 32'hC);
        run_one("R5 word@4", 3'd4, 2'd2, 0, 0);
        chk("R5 word@4 lit cas", 32'(cas_n), 32'h0F);
        chk("R5 word@4 lit ad2", 32'(ad2), 1);
        run_one("R6 half@3", 3'd3, 2'd1, 0, 0);
        chk("R6 half@3 lit cas", 32'(cas_n), 32'hE7);
        chk("R6 half@3 span", 32'(span_err), 1);
        run_one("R6 dword", 3'd0, 2'd3, 0, 0);
        chk("R6 dword lit cas", 32'(cas_n), 32'h00);
    endtask

    task automatic t_le_byte;  // R3 lane mirror
        run_one("R3 le byte@0", 3'd0, 2'd0, 1, 0);
        chk("R3 le byte@0 lane7", 32'(cas_n), 32'h7F);
        chk("R3 le byte@0 cbe", 32'(cbe_n), 32'h7);
    endtask

    task automatic t_sweep;  // R3 R4 R5 R6 R7 R8 R9 full sweep
        for (int le = 0; le < 2; le++)
            for (int sz = 0; sz < 4; sz++)
                for (int a = 0; a < 8; a++)
                    for (int io = 0; io < 2; io++)
                        run_one($sformatf("R4 sweep le=%0d sz=%0d a=%0d io=%0d", le, sz, a, io),
                                3'(a), 2'(sz), 1'(le), 1'(io));
    endtask

    task automatic t_faults;  // R8 R9
        run_one("R8 le word@2", 3'd2, 2'd2, 1, 1);
        chk("R8 le word@2 fault", 32'(le_fault), 1);
        run_one("R9 be word@6", 3'd6, 2'd2, 0, 0);
        chk("R9 be word@6 wrap", 32'(wrap_err), 1);
    endtask

    task automatic t_io;  // R7
        run_one("R7 io byte@6", 3'd6, 2'd0, 0, 1);
        chk("R7 io ad_low", 32'(ad_low), 2);
    endtask

    task automatic t_hold;  // R2: no start leaves result untouched
        run_one("R2 base", 3'd2, 2'd1, 0, 0);
        @(negedge clk);
        cpu_addr = 3'd5; xfer_size = 2'd0; le_mode = 1'b1; io_cycle = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R2 held");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stated();
        t_le_byte();
        t_io();
        t_faults();
        t_hold();
        t_sweep();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule